// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block sits beside a flash array and rules on every program or erase request aimed at one of its sectors. Each sector carries two protection flags. One is a volatile dynamic flag that reset returns to the unprotected state. The other is a persistent flag held in storage that reset leaves alone. A single lock flag freezes the persistent flags. Once set, it stays set until the block is reset. On top of these stored flags sit two hardware overrides. A write-protect pin shields one outermost sector, and a supply-good input withholds every grant and drops every command while the supply is low.

A command port sets or clears the dynamic flags, programs single persistent flags, erases all persistent flags and sets the lock. Persistent-flag operations are multi-cycle, and a busy output covers them. A query port takes a sector index and returns a registered allow flag and a two-bit reason code one cycle later. A sequence input brackets a multi-cycle access. While it is high, the write-protect pin value captured at its start is used instead of the live pin.

Top module: `sector_guard`

## Requirements
- R1: A query on a sector whose persistent flag and dynamic flag are both 1 (1 = unprotected, 0 = protected), with the pin and supply not blocking, returns allow=1 and reason 2'b00.
- R2: A sector whose persistent flag is 0 returns allow=0 and reason 2'b01 whatever its dynamic flag holds.
- R3: A sector whose persistent flag is 1 and dynamic flag is 0 returns allow=0 and reason 2'b10.
- R4: Command op 3'b101 sets the lock (lock flag 0 = locked) and answers cmd_done=1, cmd_ok=1 on the next cycle. No command ever clears the lock; only reset does. The lock alone changes no query result.
- R5: While locked, op 3'b011 (program one persistent flag to 0) and op 3'b100 (erase all persistent flags to 1) answer cmd_done=1, cmd_ok=0 on the next cycle and change no flag. The dynamic commands are still accepted.
- R6: An accepted persistent operation raises cmd_busy from the next cycle and reports cmd_done=1, cmd_ok=1 exactly NVM_CYCLES cycles after acceptance. Commands that arrive while busy are ignored.
- R7: While the effective write-protect level is low, sector NUM_SECTORS-1 (WP_AT_HIGH=1) or sector 0 (WP_AT_HIGH=0) returns allow=0 and reason 2'b11 regardless of its flags. Other sectors are unaffected. With the level high, the stored flags decide.
- R8: While seq_active is high, the write-protect level is the pin value sampled on the last clock edge before seq_active rose, so a pin change in mid-sequence has no effect.
- R9: While supply_ok is low, commands are ignored with no cmd_done, any persistent operation in progress is dropped without changing a flag and cmd_busy falls, and queries return allow=0 and reason 2'b11.
- R10: Reset sets every dynamic flag to 1 and the lock to unlocked. Persistent flags keep their values across reset.
- R11: Every query sampled on a clock edge produces res_valid=1 on that same edge, so it is visible one cycle after the request. res_allow is 1 exactly when res_reason is 2'b00.
- R12: Command ops 3'b001 (dynamic flag to 0) and 3'b010 (dynamic flag to 1) complete with cmd_done=1, cmd_ok=1 on the next cycle. Op 3'b000 and ops 3'b110 and 3'b111 are rejected with cmd_done=1, cmd_ok=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | High when the supply is good enough to write |
| wp_n | input | 1 | Write-protect pin, low protects the outermost sector |
| seq_active | input | 1 | High for the duration of an access sequence; freezes the pin level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_sector | input | SECT_W | Target sector of the command |
| cmd_busy | output | 1 | A persistent-flag operation is in progress |
| cmd_done | output | 1 | One-cycle pulse reporting command completion |
| cmd_ok | output | 1 | Command accepted and applied (valid with cmd_done) |
| qry_valid | input | 1 | Query strobe |
| qry_sector | input | SECT_W | Sector being queried |
| res_valid | output | 1 | Query result valid |
| res_allow | output | 1 | Program or erase allowed |
| res_reason | output | 2 | 00 allowed, 01 persistent flag, 10 dynamic flag, 11 pin or supply |

## Verification
On every cycle, the checker confirms several properties. The lock never leaves the locked state, and the persistent flags hold still while the lock is set. A low supply yields a hardware-reason denial and silences the command port. Each query gets a result exactly one cycle later, and the allow flag always agrees with the reason code. The dynamic flags also stay untouched while a persistent operation is busy. Other behaviours are shown only by the directed scenarios: the full grid of lock, persistent and dynamic flag values with their reason codes, and the pin override on the outermost sector with its freeze during a sequence. The scenarios also cover the exact busy length, the discarded operation after a supply drop, and persistent flags surviving a reset that clears the lock.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'b000,
    OP_DYN_PROT   = 3'b001,
    OP_DYN_UNPROT = 3'b010,
    OP_PER_PROG   = 3'b011,
    OP_PER_ERASE  = 3'b100,
    OP_LOCK       = 3'b101
  } sg_op_e;

  typedef enum logic [1:0] {
    RSN_OK   = 2'b00,
    RSN_PERS = 2'b01,
    RSN_DYN  = 2'b10,
    RSN_HW   = 2'b11
  } sg_reason_e;

  // write strobes from the command engine to the flag store
  typedef struct packed {
    logic dyn_we;
    logic dyn_val;
    logic pers_prog;
    logic pers_erase;
    logic lock_set;
  } sg_wr_t;

endpackage

// File: rtl/sg_cmd_fsm.sv
module sg_cmd_fsm
  import sg_pkg::*;
#(
  parameter int SECT_W     = 3,
  parameter int NVM_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              lock_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  output sg_wr_t            wr,
  output logic [SECT_W-1:0] wr_sector,
  output logic              busy,
  output logic              done,
  output logic              ok
);

  localparam int CNT_W = $clog2(NVM_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NVM_CYCLES - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              erase_q, erase_d;
  logic [SECT_W-1:0] sec_q, sec_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;
  logic              pend_en;

  // next-state
  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    erase_d   = erase_q;
    sec_d     = sec_q;
    done_d    = 1'b0;
    ok_d      = 1'b0;
    pend_en   = 1'b0;
    wr        = '0;
    wr_sector = cmd_sector;

    if (!supply_ok) begin
      // undervoltage: drop everything, back to idle
      busy_d = 1'b0;
    end else if (busy_q) begin
      wr_sector = sec_q;
      if (cnt_q == '0) begin
        busy_d        = 1'b0;
        done_d        = 1'b1;
        ok_d          = 1'b1;
        wr.pers_prog  = !erase_q;
        wr.pers_erase = erase_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (cmd_valid) begin
      done_d = 1'b1;
      case (sg_op_e'(cmd_op))
        OP_DYN_PROT: begin
          wr.dyn_we  = 1'b1;
          wr.dyn_val = 1'b0;
          ok_d       = 1'b1;
        end
        OP_DYN_UNPROT: begin
          wr.dyn_we  = 1'b1;
          wr.dyn_val = 1'b1;
          ok_d       = 1'b1;
        end
        OP_PER_PROG, OP_PER_ERASE: begin
          if (lock_n) begin
            done_d  = 1'b0;
            busy_d  = 1'b1;
            cnt_d   = CNT_LOAD;
            pend_en = 1'b1;
            erase_d = (cmd_op == OP_PER_ERASE);
            sec_d   = cmd_sector;
          end
        end
        OP_LOCK: begin
          wr.lock_set = 1'b1;
          ok_d        = 1'b1;
        end
        default: ok_d = 1'b0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      sec_q   <= '0;
    end else if (pend_en) begin
      erase_q <= erase_d;
      sec_q   <= sec_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign ok   = ok_q;

endmodule

// File: rtl/sg_bit_store.sv
module sg_bit_store
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  sg_wr_t                 wr,
  input  logic [SECT_W-1:0]      wr_sector,
  output logic [NUM_SECTORS-1:0] dyn_bits,
  output logic [NUM_SECTORS-1:0] pers_bits,
  output logic                   lock_n
);

  logic [NUM_SECTORS-1:0] sel;
  logic [NUM_SECTORS-1:0] dyn_q, dyn_d;
  logic [NUM_SECTORS-1:0] pers_q, pers_d;
  logic                   lock_q, lock_d;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sel
    assign sel[i] = (wr_sector == SECT_W'(i));
  end

  always_comb begin
    for (int i = 0; i < NUM_SECTORS; i++) begin
      dyn_d[i] = (wr.dyn_we && sel[i]) ? wr.dyn_val : dyn_q[i];
      if (wr.pers_erase)
        pers_d[i] = 1'b1;
      else if (wr.pers_prog && sel[i])
        pers_d[i] = 1'b0;
      else
        pers_d[i] = pers_q[i];
    end
    lock_d = lock_q & ~wr.lock_set;
  end

  // volatile flags and lock: cleared to the open state by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dyn_q  <= '1;
      lock_q <= 1'b1;
    end else begin
      dyn_q  <= dyn_d;
      lock_q <= lock_d;
    end
  end

  // persistent flags: stand-in for non-volatile cells, untouched by reset
  always_ff @(posedge clk) begin
    if (wr.pers_erase || wr.pers_prog)
      pers_q <= pers_d;
  end

  assign dyn_bits  = dyn_q;
  assign pers_bits = pers_q;
  assign lock_n    = lock_q;

endmodule

// File: rtl/sg_verdict.sv
module sg_verdict
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = 3,
  parameter bit WP_AT_HIGH  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   supply_ok,
  input  logic                   wp_n,
  input  logic                   seq_active,
  input  logic                   qry_valid,
  input  logic [SECT_W-1:0]      qry_sector,
  input  logic [NUM_SECTORS-1:0] dyn_bits,
  input  logic [NUM_SECTORS-1:0] pers_bits,
  output logic                   res_valid,
  output logic                   res_allow,
  output logic [1:0]             res_reason
);

  localparam logic [SECT_W-1:0] EDGE_SECT =
    WP_AT_HIGH ? SECT_W'(NUM_SECTORS - 1) : '0;

  logic       wp_hold_q;
  logic       wp_eff;
  logic       hw_block;
  sg_reason_e rsn_d;
  logic       valid_q;
  logic       allow_q;
  logic [1:0] rsn_q;

  // pin follows the live level while idle, frozen while a sequence runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wp_hold_q <= 1'b0;
    else if (!seq_active)
      wp_hold_q <= wp_n;
  end

  assign wp_eff = seq_active ? wp_hold_q : wp_n;

  always_comb begin
    hw_block = !supply_ok || (!wp_eff && (qry_sector == EDGE_SECT));
    if (hw_block)
      rsn_d = RSN_HW;
    else if (!pers_bits[qry_sector])
      rsn_d = RSN_PERS;
    else if (!dyn_bits[qry_sector])
      rsn_d = RSN_DYN;
    else
      rsn_d = RSN_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else
      valid_q <= qry_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      rsn_q   <= RSN_HW;
    end else if (qry_valid) begin
      allow_q <= (rsn_d == RSN_OK);
      rsn_q   <= rsn_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_allow  = allow_q;
  assign res_reason = rsn_q;

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int NVM_CYCLES  = 4,
  parameter bit WP_AT_HIGH  = 1'b1,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              wp_n,
  input  logic              seq_active,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic              cmd_ok,
  input  logic              qry_valid,
  input  logic [SECT_W-1:0] qry_sector,
  output logic              res_valid,
  output logic              res_allow,
  output logic [1:0]        res_reason
);

  logic [1:0]             rst_pipe_q;
  logic                   rst_sync_n;
  sg_wr_t                 wr;
  logic [SECT_W-1:0]      wr_sector;
  logic [NUM_SECTORS-1:0] dyn_bits;
  logic [NUM_SECTORS-1:0] pers_bits;
  logic                   lock_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sg_cmd_fsm #(
    .SECT_W     (SECT_W),
    .NVM_CYCLES (NVM_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .supply_ok  (supply_ok),
    .lock_n     (lock_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_sector (cmd_sector),
    .wr         (wr),
    .wr_sector  (wr_sector),
    .busy       (cmd_busy),
    .done       (cmd_done),
    .ok         (cmd_ok)
  );

  sg_bit_store #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (wr),
    .wr_sector (wr_sector),
    .dyn_bits  (dyn_bits),
    .pers_bits (pers_bits),
    .lock_n    (lock_n)
  );

  sg_verdict #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W),
    .WP_AT_HIGH  (WP_AT_HIGH)
  ) u_verdict (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .supply_ok  (supply_ok),
    .wp_n       (wp_n),
    .seq_active (seq_active),
    .qry_valid  (qry_valid),
    .qry_sector (qry_sector),
    .dyn_bits   (dyn_bits),
    .pers_bits  (pers_bits),
    .res_valid  (res_valid),
    .res_allow  (res_allow),
    .res_reason (res_reason)
  );

endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int NUM_SECTORS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   supply_ok,
  input logic                   qry_valid,
  input logic                   cmd_busy,
  input logic                   cmd_done,
  input logic                   res_valid,
  input logic                   res_allow,
  input logic [1:0]             res_reason,
  input logic                   lock_n,
  input logic [NUM_SECTORS-1:0] dyn_bits,
  input logic [NUM_SECTORS-1:0] pers_bits
);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |=> !lock_n); // R4

  AST_PERS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && !$isunknown(pers_bits)) |=> $stable(pers_bits)); // R5

  AST_BUSY_DYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> $stable(dyn_bits)); // R6

  AST_UV_QUERY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && !supply_ok) |=> (res_valid && !res_allow && res_reason == 2'b11)); // R9

  AST_UV_CMD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!cmd_done && !cmd_busy)); // R9

  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> res_valid); // R11

  AST_RES_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !res_valid); // R11

  AST_ALLOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_allow == (res_reason == 2'b00))); // R11

endmodule

bind sector_guard sg_guard_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .supply_ok  (supply_ok),
  .qry_valid  (qry_valid),
  .cmd_busy   (cmd_busy),
  .cmd_done   (cmd_done),
  .res_valid  (res_valid),
  .res_allow  (res_allow),
  .res_reason (res_reason),
  .lock_n     (lock_n),
  .dyn_bits   (dyn_bits),
  .pers_bits  (pers_bits)
);

// File: tb/sector_guard_tb.sv
module sector_guard_tb;

  localparam int NS   = 8;
  localparam int SW   = 3;
  localparam int NVMC = 4;
  localparam int EDGE = NS - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok;
  logic          wp_n;
  logic          seq_active;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [SW-1:0] cmd_sector;
  logic          cmd_busy;
  logic          cmd_done;
  logic          cmd_ok;
  logic          qry_valid;
  logic [SW-1:0] qry_sector;
  logic          res_valid;
  logic          res_allow;
  logic [1:0]    res_reason;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sector_guard #(
    .NUM_SECTORS (NS),
    .NVM_CYCLES  (NVMC),
    .WP_AT_HIGH  (1'b1)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .wp_n       (wp_n),
    .seq_active (seq_active),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_sector (cmd_sector),
    .cmd_busy   (cmd_busy),
    .cmd_done   (cmd_done),
    .cmd_ok     (cmd_ok),
    .qry_valid  (qry_valid),
    .qry_sector (qry_sector),
    .res_valid  (res_valid),
    .res_allow  (res_allow),
    .res_reason (res_reason)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // query a sector and compare valid, reason and allow
  task automatic expect_q(input string req, input int sec, input int exp_rsn);
    qry_valid  = 1'b1;
    qry_sector = SW'(sec);
    @(negedge clk);
    qry_valid = 1'b0;
    chk({req, " valid"},  int'(res_valid),  1);
    chk({req, " reason"}, int'(res_reason), exp_rsn);
    chk({req, " allow"},  int'(res_allow),  (exp_rsn == 0) ? 1 : 0);
  endtask

  // single-cycle command; checks done and ok
  task automatic cmd_imm(input string req, input logic [2:0] op, input int sec,
                         input int exp_done, input int exp_ok);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_sector = SW'(sec);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " done"}, int'(cmd_done), exp_done);
    if (exp_done == 1) chk({req, " ok"}, int'(cmd_ok), exp_ok);
  endtask

  // persistent command, accepted when unlocked; checks busy length
  task automatic cmd_nvm(input string req, input logic [2:0] op, input int sec);
    int cyc;
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_sector = SW'(sec);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " busy"}, int'(cmd_busy), 1);
    cyc = 0;
    while (!cmd_done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk({req, " cycles"}, cyc, NVMC);
    chk({req, " ok"}, int'(cmd_ok), 1);
  endtask

  task automatic t_reset_state();
    cmd_nvm("R10 erase-all after reset (unlocked)", 3'b100, 0);
    for (int s = 0; s < NS; s++) expect_q("R10 R1 dynamic flags open", s, 0);
  endtask

  task automatic t_unlocked_grid();
    expect_q("R1 p1 d1", 2, 0);
    cmd_imm("R12 dyn protect", 3'b001, 2, 1, 1);
    expect_q("R3 p1 d0", 2, 2);
    cmd_nvm("R6 program persistent", 3'b011, 2);
    expect_q("R2 p0 d0", 2, 1);
    cmd_imm("R12 dyn unprotect", 3'b010, 2, 1, 1);
    expect_q("R2 p0 d1", 2, 1);
    cmd_nvm("R6 erase-all", 3'b100, 0);
    expect_q("R6 erase-all restores", 2, 0);
  endtask

  task automatic t_busy();
    cmd_valid  = 1'b1;
    cmd_op     = 3'b011;
    cmd_sector = SW'(1);
    @(negedge clk);
    chk("R6 busy after accept", int'(cmd_busy), 1);
    cmd_op     = 3'b001;
    cmd_sector = SW'(5);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 command during busy no done", int'(cmd_done), 0);
    for (int i = 0; i < 10 && !cmd_done; i++) @(negedge clk);
    chk("R6 completion ok", int'(cmd_ok), 1);
    expect_q("R6 ignored dyn command", 5, 0);
    expect_q("R6 programmed sector", 1, 1);
    cmd_nvm("R6 erase-all", 3'b100, 0);
  endtask

  task automatic t_bad_ops();
    cmd_imm("R12 op 110 rejected", 3'b110, 0, 1, 0);
    cmd_imm("R12 op 111 rejected", 3'b111, 0, 1, 0);
    cmd_imm("R12 op 000 rejected", 3'b000, 0, 1, 0);
  endtask

  task automatic t_pin();
    wp_n = 1'b0;
    @(negedge clk);
    expect_q("R7 pin low outermost", EDGE, 3);
    expect_q("R7 pin low other sector", EDGE - 1, 0);
    expect_q("R7 pin low sector 0", 0, 0);
    wp_n = 1'b1;
    @(negedge clk);
    expect_q("R7 pin high outermost", EDGE, 0);
    cmd_imm("R7 dyn protect outermost", 3'b001, EDGE, 1, 1);
    expect_q("R7 pin high uses flags", EDGE, 2);
    cmd_imm("R7 dyn unprotect outermost", 3'b010, EDGE, 1, 1);
    // freeze during a sequence
    seq_active = 1'b1;
    @(negedge clk);
    wp_n = 1'b0;
    @(negedge clk);
    expect_q("R8 mid-sequence pin drop ignored", EDGE, 0);
    seq_active = 1'b0;
    expect_q("R8 R7 after sequence pin applies", EDGE, 3);
    seq_active = 1'b1;
    @(negedge clk);
    wp_n = 1'b1;
    @(negedge clk);
    expect_q("R8 mid-sequence pin rise ignored", EDGE, 3);
    seq_active = 1'b0;
    @(negedge clk);
    expect_q("R8 after sequence pin high", EDGE, 0);
  endtask

  task automatic t_supply();
    cmd_valid  = 1'b1;
    cmd_op     = 3'b011;
    cmd_sector = SW'(0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 program started", int'(cmd_busy), 1);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 busy dropped", int'(cmd_busy), 0);
    chk("R9 no done", int'(cmd_done), 0);
    expect_q("R9 query denied low supply", 3, 3);
    cmd_imm("R9 command ignored", 3'b001, 6, 0, 0);
    supply_ok = 1'b1;
    repeat (NVMC + 2) @(negedge clk);
    chk("R9 no late completion", int'(cmd_busy), 0);
    expect_q("R9 aborted program left flag", 0, 0);
    expect_q("R9 ignored dyn command", 6, 0);
  endtask

  task automatic t_locked();
    cmd_nvm("R5 setup program sector 3", 3'b011, 3);
    cmd_imm("R4 set lock", 3'b101, 0, 1, 1);
    expect_q("R4 lock alone no effect", 2, 0);
    expect_q("R4 locked p0 d1", 3, 1);
    cmd_imm("R5 dyn still accepted", 3'b001, 3, 1, 1);
    expect_q("R4 locked p0 d0", 3, 1);
    expect_q("R4 locked p1 d1", 4, 0);
    cmd_imm("R5 dyn protect sector 4", 3'b001, 4, 1, 1);
    expect_q("R4 locked p1 d0", 4, 2);
    cmd_imm("R5 dyn unprotect sector 4", 3'b010, 4, 1, 1);
    cmd_imm("R5 program rejected when locked", 3'b011, 4, 1, 0);
    expect_q("R5 program had no effect", 4, 0);
    cmd_imm("R5 erase-all rejected when locked", 3'b100, 0, 1, 0);
    expect_q("R5 erase-all had no effect", 3, 1);
    cmd_imm("R4 lock again", 3'b101, 0, 1, 1);
    for (int i = 0; i < 3; i++) cmd_imm("R4 lock stays set", 3'b011, 5, 1, 0);
    expect_q("R4 sector 5 untouched", 5, 0);
  endtask

  task automatic t_after_reset();
    do_reset();
    expect_q("R10 persistent kept across reset", 3, 1);
    expect_q("R10 dynamic reopened", 4, 0);
    cmd_nvm("R4 R10 reset clears lock", 3'b100, 0);
    expect_q("R10 erase after reset", 3, 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    supply_ok  = 1'b1;
    wp_n       = 1'b1;
    seq_active = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 3'b000;
    cmd_sector = '0;
    qry_valid  = 1'b0;
    qry_sector = '0;
    do_reset();
    chk("R10 no result after reset", int'(res_valid), 0);
    chk("R10 not busy after reset", int'(cmd_busy), 0);
    t_reset_state();
    t_unlocked_grid();
    t_busy();
    t_bad_ops();
    t_pin();
    t_supply();
    t_locked();
    t_after_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule